// File: doc/BRIEF.md
# Programmable Wake-up Down-Counter Timer

A periodic wake-up timer for a real-time-clock subsystem. A down-counter is loaded from a 16-bit reload register and counts ticks from one of two sources. One source is the kernel clock divided by 16, 8, 4 or 2, using a free-running prefix counter. The other is an externally supplied one-pulse-per-second tick. Each time the counter passes zero it reloads itself and raises a sticky wake-up flag. The flag drives the interrupt output when interrupts are enabled.

Software reaches the timer through a simple synchronous register port with three words. The select field can stretch the reload by 2^16 for long periods. A write-allowed status bit guards reprogramming. The bit is low while the timer runs, and it rises two selected ticks after the timer is stopped. Enable and reload writes made while the bit is low are dropped.

Top module: `wkup_timer`

## Requirements
- R1: After reset, word 0 and word 2 read 0, word 1 reads 2 (flag 0, write-allowed 1), and the flag and interrupt outputs are 0.
- R2: Word 0 holds enable in bit 0, source select in bits 3:1 and interrupt enable in bit 4. Select codes 000, 001, 010 and 011 count one tick every 16, 8, 4 and 2 kernel cycles, taken from a 4-bit counter that free-runs from reset and ticks when its low bits are all ones.
- R3: Select codes 100 and 101 count one tick per cycle in which `sec_tick_i` is high.
- R4: Select codes 110 and 111 count `sec_tick_i` ticks, with 65536 added to the reload value.
- R5: An accepted enable loads the effective reload value E. On each selected tick the counter decrements, and a tick that finds it at zero reloads E and sets the flag, so the flag event repeats every E+1 ticks.
- R6: The flag (word 1 bit 0) stays set until word 1 is written with bit 0 equal to 0. An expiry in the same cycle as that clear leaves the flag set.
- R7: `irq_o` equals the flag ANDed with the interrupt-enable bit.
- R8: Write-allowed (word 1 bit 1, also `wr_ok_o`) is 0 while enabled, and returns to 1 on the second selected tick after a disable.
- R9: An enable write, or a write to the reload register (word 2), made while write-allowed is 0 is ignored.
- R10: The active source is captured only when an enable is accepted. A select written while running shows in word 0 but does not change the count source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | Seconds tick, one cycle high per tick |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 control, 1 status, 2 reload |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| wkup_flag_o | output | 1 | Sticky wake-up flag |
| irq_o | output | 1 | Wake-up interrupt |
| wr_ok_o | output | 1 | Write-allowed status |

## Verification
A write takes effect on the clock edge that samples it. Register contents, flag and write-allowed therefore show their new values right after that edge, and read data follows the address combinationally. A tick seen at an edge updates the counter and flag at that same edge, so an expiry appears one register stage after the tick condition. A behavioural model in the bench advances on the same edge from the same inputs, and every output is compared two nanoseconds after each rising edge, well away from the edge on which inputs change.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned DIV_LOG = 4;  // largest kernel divide is 2**DIV_LOG
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_STAT   = 2'd1,
    ADDR_RELOAD = 2'd2
  } wkt_addr_e;

  // codes 11x stretch the reload by one extra MSB
  function automatic logic sel_ext(input logic [SEL_W-1:0] s);
    return s[2] & s[1];
  endfunction
endpackage

// File: rtl/wkt_tick_sel.sv
module wkt_tick_sel
  import wkt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_tick_i,
  input  logic [SEL_W-1:0] asel_i,
  output logic             tick_o
);
  localparam int unsigned N_DIV = 4;

  logic [DIV_LOG-1:0] pre_q;
  logic [N_DIV-1:0]   div_tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;

  // code i divides by 2**(DIV_LOG-i)
  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    assign div_tick[i] = &pre_q[DIV_LOG-1-i:0];
  end

  assign tick_o = asel_i[2] ? sec_tick_i : div_tick[asel_i[1:0]];

  // R2
  div16_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asel_i[2] && asel_i[1:0] == 2'd0 && tick_o) |=> !tick_o);
endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
#(
  parameter int unsigned RELOAD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [RELOAD_W-1:0] wdata_i,
  input  logic                tick_i,
  input  logic                flag_i,
  output logic [RELOAD_W-1:0] rdata_o,
  output logic                en_o,
  output logic                load_o,
  output logic                clr_o,
  output logic                irq_en_o,
  output logic [SEL_W-1:0]    asel_o,
  output logic [RELOAD_W:0]   eff_o,
  output logic                wr_ok_o
);
  localparam logic [1:0] SETTLE_DONE = 2'd2;

  logic                en_q, irq_en_q;
  logic [SEL_W-1:0]    sel_q, asel_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [1:0]          settle_q;
  logic                ctrl_we, stat_we, rld_we, dis;

  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);
  assign stat_we = we_i && (addr_i == ADDR_STAT);
  assign rld_we  = we_i && (addr_i == ADDR_RELOAD);

  assign wr_ok_o = !en_q && (settle_q == SETTLE_DONE);
  assign load_o  = ctrl_we && wdata_i[0] && wr_ok_o;
  assign dis     = ctrl_we && !wdata_i[0] && en_q;
  assign clr_o   = stat_we && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q     <= 1'b0;
      irq_en_q <= 1'b0;
      sel_q    <= '0;
      asel_q   <= '0;
      reload_q <= '0;
      settle_q <= SETTLE_DONE;
    end else begin
      if (ctrl_we) begin
        sel_q    <= wdata_i[SEL_W:1];
        irq_en_q <= wdata_i[SEL_W+1];
      end
      if (load_o) begin
        en_q   <= 1'b1;
        asel_q <= wdata_i[SEL_W:1];
      end else if (dis) begin
        en_q <= 1'b0;
      end
      if (dis)                                               settle_q <= '0;
      else if (!en_q && tick_i && settle_q != SETTLE_DONE)   settle_q <= settle_q + 1'b1;
      if (rld_we && wr_ok_o) reload_q <= wdata_i;
    end

  // on load the new select decides the extension
  assign eff_o = {load_o ? sel_ext(wdata_i[SEL_W:1]) : sel_ext(asel_q), reload_q};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL:   rdata_o[SEL_W+1:0] = {irq_en_q, sel_q, en_q};
      ADDR_STAT:   rdata_o[1:0]       = {wr_ok_o, flag_i};
      ADDR_RELOAD: rdata_o            = reload_q;
      default:     rdata_o            = '0;
    endcase
  end

  assign en_o     = en_q;
  assign irq_en_o = irq_en_q;
  assign asel_o   = asel_q;

  // R9
  reload_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_o |=> $stable(reload_q));
  // R10
  asel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> $stable(asel_q));
  // R8
  settle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> !wr_ok_o);
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int unsigned RELOAD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [RELOAD_W:0] eff_i,
  output logic              flag_o
);
  logic [RELOAD_W:0] cnt_q;
  logic              expire;

  assign expire = en_i && !load_i && tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (load_i)              cnt_q <= eff_i;
      else if (en_i && tick_i) cnt_q <= (cnt_q == '0) ? eff_i : cnt_q - 1'b1;
      if (expire)      flag_o <= 1'b1;  // set beats clear
      else if (clr_i)  flag_o <= 1'b0;
    end

  // R5
  expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && tick_i && cnt_q == '0) |=> flag_o);
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !tick_i) |=> $stable(cnt_q));
  // R6
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer
  import wkt_pkg::*;
#(
  parameter int unsigned RELOAD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sec_tick_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [RELOAD_W-1:0] reg_wdata_i,
  output logic [RELOAD_W-1:0] reg_rdata_o,
  output logic                wkup_flag_o,
  output logic                irq_o,
  output logic                wr_ok_o
);
  logic              tick, en, load, clr, irq_en;
  logic [SEL_W-1:0]  asel;
  logic [RELOAD_W:0] eff;

  wkt_tick_sel i_tick (
    .clk_i, .rst_ni, .sec_tick_i, .asel_i(asel), .tick_o(tick)
  );

  wkt_regs #(.RELOAD_W(RELOAD_W)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .tick_i(tick), .flag_i(wkup_flag_o), .rdata_o(reg_rdata_o), .en_o(en),
    .load_o(load), .clr_o(clr), .irq_en_o(irq_en), .asel_o(asel), .eff_o(eff),
    .wr_ok_o
  );

  wkt_counter #(.RELOAD_W(RELOAD_W)) i_cnt (
    .clk_i, .rst_ni, .en_i(en), .load_i(load), .tick_i(tick), .clr_i(clr),
    .eff_i(eff), .flag_o(wkup_flag_o)
  );

  assign irq_o = wkup_flag_o & irq_en;

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wkup_flag_o || !irq_en) |-> !irq_o);
endmodule

// File: tb/test_wkup_timer.sv
`timescale 1ns/1ps
module test_wkup_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        flag, irq, wr_ok;

  int n_chk = 0, n_bad = 0;
  string cur = "R1";
  int sec_mode = 0, sec_cnt = 0;

  // reference model state
  int m_pre, m_cnt, m_rld, m_settle, m_div;
  bit m_en, m_irqen, m_flag, m_tk, m_ok, m_acc, m_dis, m_exp;
  bit [2:0] m_sel, m_asel;

  always #4 clk = ~clk;

  wkup_timer i_wkup_timer (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(sec), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .wkup_flag_o(flag), .irq_o(irq), .wr_ok_o(wr_ok)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    sec_cnt++;
    sec = (sec_mode == 2) || (sec_mode == 1 && sec_cnt % 5 == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_rld = 0; m_settle = 2;
      m_en = 0; m_irqen = 0; m_flag = 0; m_sel = 0; m_asel = 0;
    end else begin
      m_div = 16 >> m_asel[1:0];
      m_tk  = m_asel[2] ? sec : ((m_pre % m_div) == m_div - 1);
      m_ok  = !m_en && m_settle == 2;
      m_acc = we && addr == 0 && wd[0] && m_ok;
      m_dis = we && addr == 0 && !wd[0] && m_en;
      m_exp = m_en && m_tk && m_cnt == 0;
      if (m_acc) m_cnt = m_rld + ((wd[3] && wd[2]) ? 65536 : 0);
      else if (m_en && m_tk)
        m_cnt = (m_cnt == 0) ? m_rld + ((m_asel[2] && m_asel[1]) ? 65536 : 0) : m_cnt - 1;
      if (m_exp) m_flag = 1;
      else if (we && addr == 1 && !wd[0]) m_flag = 0;
      if (m_dis) m_settle = 0;
      else if (!m_en && m_tk && m_settle < 2) m_settle++;
      if (we && addr == 2 && m_ok) m_rld = wd;
      if (we && addr == 0) begin m_sel = wd[3:1]; m_irqen = wd[4]; end
      if (m_acc) begin m_en = 1; m_asel = wd[3:1]; end
      else if (m_dis) m_en = 0;
      m_pre = (m_pre + 1) % 16;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      m_ok = !m_en && m_settle == 2;
      check(cur, flag, m_flag);
      check("R7 irq", irq, m_flag && m_irqen);
      check("R8 wr_ok", wr_ok, m_ok);
      case (addr)
        2'd0: check(cur, rdata, {m_irqen, m_sel, m_en});
        2'd1: check(cur, rdata, {m_ok, m_flag});
        2'd2: check(cur, rdata, m_rld[15:0]);
        default: check(cur, rdata, 0);
      endcase
    end
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wd = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #3 v = rdata;
  endtask

  task automatic wait_ok();
    @(negedge clk);
    while (!wr_ok) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 stat", v, 2);
    rd(2, v); check("R1 reload", v, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);

    cur = "R5";
    wr(2, 3); wr(0, 16'h17);           // /2, irq on
    repeat (40) @(negedge clk);
    check("R8 running", wr_ok, 0);

    cur = "R6";                         // continuous clears race expiries
    @(negedge clk); we = 1; addr = 1; wd = 0;
    repeat (20) @(negedge clk);
    we = 0;
    repeat (10) @(negedge clk);

    cur = "R9";
    wr(2, 7); rd(2, v); check("R9 reload locked", v, 3);
    wr(0, 16'h16);
    wr(0, 16'h17);
    rd(0, v); check("R9 enable dropped", v[0], 0);
    wait_ok();
    check("R8 settled", wr_ok, 1);
    wr(2, 1); rd(2, v); check("R9 reload open", v, 1);

    cur = "R2";
    for (int s = 0; s < 3; s++) begin
      wr(0, 16'(1 | (s << 1) | 16'h10));
      repeat (70) @(negedge clk);
      wr(0, 16'(s << 1));
      wait_ok();
    end

    cur = "R10";
    wr(0, 16'h17);
    repeat (10) @(negedge clk);
    wr(0, 16'h11);                      // select /16 while running
    repeat (30) @(negedge clk);
    rd(0, v); check("R10 ctrl shows new sel", v, 16'h11);
    wr(0, 16'h10); wait_ok();
    wr(0, 16'h11);
    repeat (60) @(negedge clk);
    wr(0, 16'h10); wait_ok();

    cur = "R7";
    wr(0, 16'h07);
    repeat (20) @(negedge clk);
    check("R7 masked irq", irq, 0);
    wr(0, 16'h06); wait_ok();

    cur = "R3";
    sec_mode = 1;
    wr(0, 16'h19);
    repeat (60) @(negedge clk);
    wr(0, 16'h18); wait_ok();
    wr(0, 16'h1B);
    repeat (60) @(negedge clk);
    wr(0, 16'h1A); wait_ok();

    cur = "R4";
    wr(1, 0);
    sec_mode = 2;
    wr(0, 16'h1D);                      // 110, reload 1 -> 65537
    repeat (65000) @(negedge clk);
    check("R4 no early flag", flag, 0);
    repeat (545) @(negedge clk);
    check("R4 extended expiry", flag, 1);
    wr(0, 16'h1C); wait_ok();

    finish_run();
  end
endmodule